// File: doc/BRIEF.md
# Biphase-Mark Stereo Frame Decoder

This block turns a biphase-mark serial audio stream into stereo samples. The line is sampled by a system clock that runs at four times the nominal bit rate, so one half-cell lasts two clocks. The block measures the time between line transitions and sorts each interval into one, two or three half-cells. An interval of three half-cells cannot occur inside data, so it marks the start of a preamble. The three intervals that follow it identify the preamble as block start, left or right.

After a valid preamble, the block assembles the remaining subframe slots: a 24-bit sample, sent least significant bit first, followed by four control bits. Each finished sample goes into the holding register for its channel and stays there until the next sample for that channel arrives. A lock flag reports whether block-start preambles keep arriving with clean coding. When the line stops toggling, a loss detector clears all decoded outputs to a defined state.

Top module: `bmc_frame_decoder`

## Requirements
- R1: A subframe's 24 data slots, received least significant bit first, appear on the channel's sample output. The first data slot is bit 0 and the last is bit 23.
- R2: The four slots after the data are stored on the channel's control output in this order: bit 0 = validity, bit 1 = user, bit 2 = channel status, bit 3 = parity.
- R3: The preamble's half-cell levels select the channel, with the pattern complemented when the preceding level is high. 11101000 (block start) and 11100010 select left. 11100100 selects right.
- R4: Storing a sample for one channel leaves the other channel's sample and control outputs unchanged.
- R5: `parity_err` goes high after a subframe whose 28 post-preamble slots hold an odd number of ones. It goes low after a subframe where that count is even. It holds its value between subframes.
- R6: After LOSS_CLKS clocks with no line transition, `sig_lost` goes high, `lock` goes low, and both samples, both control words and `parity_err` read zero. The next transition clears `sig_lost`.
- R7: `lock` rises after a block-start preamble is decoded. It stays high across left and right subframes that follow it.
- R8: `lock` falls if no block-start preamble is decoded within (BLOCK_FRAMES+1)*256 clocks of the previous one.
- R9: A coding violation drops `lock`. Violations are an interval longer than 7 clocks, or an unknown preamble pattern, inside a preamble or data. The subframe it occurs in stores no sample.
- R10: After reset, `lock` is low, `sig_lost` is high, and all sample, control and parity outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bmc_in | input | 1 | Biphase-mark serial line |
| lock | output | 1 | High while framing is locked |
| sig_lost | output | 1 | High when no transition has arrived for LOSS_CLKS clocks |
| left_sample | output | SAMPLE_W | Latest left-channel sample |
| left_ctrl | output | 4 | Left control bits {P,C,U,V} |
| right_sample | output | SAMPLE_W | Latest right-channel sample |
| right_ctrl | output | 4 | Right control bits {P,C,U,V} |
| parity_err | output | 1 | Parity result of the latest subframe |

## Verification
The bench builds the block with SAMPLE_W=24 and LOSS_CLKS=32, but with BLOCK_FRAMES=2 instead of 192. A block-start preamble every two frames then keeps the decoder locked, and the lock-window timeout (768 clocks) is reached after a few left/right subframes with no block start. The short window keeps the timeout case within a short run while it still uses the same counter as a full-size block.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PRE,
        ST_DATA
    } dec_state_e;

    typedef enum logic [1:0] {
        PK_BLOCK,
        PK_LEFT,
        PK_RIGHT,
        PK_NONE
    } pre_kind_e;

    // Interval length in clocks -> half-cells (0 = illegal)
    function automatic logic [1:0] classify(input int unsigned len);
        if (len >= 1 && len <= 2)      return 2'd1;
        else if (len >= 3 && len <= 4) return 2'd2;
        else if (len >= 5 && len <= 7) return 2'd3;
        else                           return 2'd0;
    endfunction

    // Three intervals following the leading three-half-cell run
    function automatic pre_kind_e decode_pre(input logic [1:0] a,
                                             input logic [1:0] b,
                                             input logic [1:0] c);
        if (a == 2'd1 && b == 2'd1 && c == 2'd3)      return PK_BLOCK;
        else if (a == 2'd3 && b == 2'd1 && c == 2'd1) return PK_LEFT;
        else if (a == 2'd2 && b == 2'd1 && c == 2'd2) return PK_RIGHT;
        else                                          return PK_NONE;
    endfunction

endpackage

// File: rtl/bmc_edge_timer.sv
module bmc_edge_timer #(
    parameter int LOSS_CLKS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    output logic       sym_valid,
    output logic [1:0] sym,
    output logic       sig_lost
);
    import bmc_pkg::*;

    localparam int CW = $clog2(LOSS_CLKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LOSS_CLKS);

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          edge_w;

    assign edge_w    = sync_q[1] ^ sync_q[2];
    assign sym_valid = edge_w;
    assign sym       = classify(int'(cnt_q) + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            cnt_q    <= CNT_MAX;
            sig_lost <= 1'b1;
        end else begin
            sync_q <= {sync_q[1:0], line};
            if (edge_w) begin
                cnt_q    <= '0;
                sig_lost <= 1'b0;
            end else begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_MAX - 1'b1) sig_lost <= 1'b1;
            end
        end
    end

    // R6
    edge_clears_lost_chk: assert property (@(posedge clk) disable iff (rst)
        edge_w |=> !sig_lost);

endmodule

// File: rtl/bmc_slot_decoder.sv
module bmc_slot_decoder #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_valid,
    input  logic [1:0]          sym,
    output logic                frm_valid,
    output logic                frm_right,
    output logic                frm_par_err,
    output logic [3:0]          frm_ctrl,
    output logic [SAMPLE_W-1:0] frm_data,
    output logic                blk_pulse,
    output logic                viol_pulse
);
    import bmc_pkg::*;

    localparam int SLOTS = SAMPLE_W + CTRL_BITS;
    localparam int CW    = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);

    dec_state_e       state_q;
    logic [1:0]       pidx_q;
    logic [1:0]       pat0_q, pat1_q;
    logic             right_q;
    logic             half_q;
    logic [CW-1:0]    bcnt_q;
    logic [SLOTS-1:0] sr_q;

    logic             bit_ev, bit_val, bad_sym, half_nx;
    logic [SLOTS-1:0] shifted;
    pre_kind_e        kind;

    assign kind    = decode_pre(pat0_q, pat1_q, sym);
    assign shifted = {bit_val, sr_q[SLOTS-1:1]};

    always_comb begin
        bit_ev  = 1'b0;
        bit_val = 1'b0;
        bad_sym = 1'b0;
        half_nx = half_q;
        if (state_q == ST_DATA && sym_valid) begin
            case (sym)
                2'd2: if (half_q) bad_sym = 1'b1;
                      else        bit_ev  = 1'b1;
                2'd1: if (half_q) begin
                          bit_ev  = 1'b1;
                          bit_val = 1'b1;
                          half_nx = 1'b0;
                      end else begin
                          half_nx = 1'b1;
                      end
                default: bad_sym = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HUNT;
            pidx_q      <= '0;
            pat0_q      <= '0;
            pat1_q      <= '0;
            right_q     <= 1'b0;
            half_q      <= 1'b0;
            bcnt_q      <= '0;
            sr_q        <= '0;
            frm_valid   <= 1'b0;
            frm_right   <= 1'b0;
            frm_par_err <= 1'b0;
            frm_ctrl    <= '0;
            frm_data    <= '0;
            blk_pulse   <= 1'b0;
            viol_pulse  <= 1'b0;
        end else begin
            frm_valid  <= 1'b0;
            blk_pulse  <= 1'b0;
            viol_pulse <= 1'b0;
            if (sym_valid) begin
                case (state_q)
                    ST_HUNT: if (sym == 2'd3) begin
                        state_q <= ST_PRE;
                        pidx_q  <= '0;
                    end
                    ST_PRE: if (sym == 2'd0) begin
                        viol_pulse <= 1'b1;
                        state_q    <= ST_HUNT;
                    end else if (pidx_q == 2'd0) begin
                        pat0_q <= sym;
                        pidx_q <= 2'd1;
                    end else if (pidx_q == 2'd1) begin
                        pat1_q <= sym;
                        pidx_q <= 2'd2;
                    end else if (kind == PK_NONE) begin
                        viol_pulse <= 1'b1;
                        state_q    <= ST_HUNT;
                    end else begin
                        state_q   <= ST_DATA;
                        right_q   <= (kind == PK_RIGHT);
                        blk_pulse <= (kind == PK_BLOCK);
                        bcnt_q    <= '0;
                        half_q    <= 1'b0;
                    end
                    ST_DATA: if (bad_sym) begin
                        viol_pulse <= 1'b1;
                        state_q    <= ST_HUNT;
                    end else begin
                        half_q <= half_nx;
                        if (bit_ev) begin
                            sr_q   <= shifted;
                            bcnt_q <= bcnt_q + 1'b1;
                            if (bcnt_q == LAST_SLOT) begin
                                frm_valid   <= 1'b1;
                                frm_right   <= right_q;
                                frm_data    <= shifted[SAMPLE_W-1:0];
                                frm_ctrl    <= shifted[SLOTS-1:SAMPLE_W];
                                frm_par_err <= ^shifted;
                                state_q     <= ST_HUNT;
                            end
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

    // R9
    viol_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> !frm_valid);

endmodule

// File: rtl/bmc_frame_store.sv
module bmc_frame_store #(
    parameter int SAMPLE_W = 24,
    parameter int WINDOW   = 768
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_valid,
    input  logic                frm_right,
    input  logic                frm_par_err,
    input  logic [3:0]          frm_ctrl,
    input  logic [SAMPLE_W-1:0] frm_data,
    input  logic                blk_pulse,
    input  logic                viol_pulse,
    input  logic                sig_lost,
    output logic                lock,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [3:0]          left_ctrl,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic [3:0]          right_ctrl,
    output logic                parity_err
);
    localparam int WW = $clog2(WINDOW + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);

    logic [WW-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst || sig_lost) begin
            lock         <= 1'b0;
            win_q        <= '0;
            left_sample  <= '0;
            left_ctrl    <= '0;
            right_sample <= '0;
            right_ctrl   <= '0;
            parity_err   <= 1'b0;
        end else begin
            if (viol_pulse) begin
                lock <= 1'b0;
            end else if (blk_pulse) begin
                lock  <= 1'b1;
                win_q <= '0;
            end else if (lock) begin
                if (win_q == WIN_LAST) lock <= 1'b0;
                else                   win_q <= win_q + 1'b1;
            end
            if (frm_valid) begin
                parity_err <= frm_par_err;
                if (frm_right) begin
                    right_sample <= frm_data;
                    right_ctrl   <= frm_ctrl;
                end else begin
                    left_sample <= frm_data;
                    left_ctrl   <= frm_ctrl;
                end
            end
        end
    end

    // R6
    lost_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        sig_lost |=> (!lock && left_sample == '0 && right_sample == '0 && !parity_err));

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(blk_pulse));

    // R4
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sig_lost && !(frm_valid && !frm_right)) |=> $stable(left_sample));

    // R9
    viol_drop_chk: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |=> !lock);

endmodule

// File: rtl/bmc_frame_decoder.sv
module bmc_frame_decoder #(
    parameter int SAMPLE_W     = 24,
    parameter int LOSS_CLKS    = 32,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bmc_in,
    output logic                lock,
    output logic                sig_lost,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [3:0]          left_ctrl,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic [3:0]          right_ctrl,
    output logic                parity_err
);
    localparam int CLK_PER_FRAME = 2 * 32 * 4;
    localparam int WINDOW        = (BLOCK_FRAMES + 1) * CLK_PER_FRAME;

    logic                sym_valid;
    logic [1:0]          sym;
    logic                frm_valid, frm_right, frm_par_err;
    logic [3:0]          frm_ctrl;
    logic [SAMPLE_W-1:0] frm_data;
    logic                blk_pulse, viol_pulse;

    bmc_edge_timer #(.LOSS_CLKS(LOSS_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .line      (bmc_in),
        .sym_valid (sym_valid),
        .sym       (sym),
        .sig_lost  (sig_lost)
    );

    bmc_slot_decoder #(.SAMPLE_W(SAMPLE_W)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .sym_valid   (sym_valid),
        .sym         (sym),
        .frm_valid   (frm_valid),
        .frm_right   (frm_right),
        .frm_par_err (frm_par_err),
        .frm_ctrl    (frm_ctrl),
        .frm_data    (frm_data),
        .blk_pulse   (blk_pulse),
        .viol_pulse  (viol_pulse)
    );

    bmc_frame_store #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW)) u_store (
        .clk          (clk),
        .rst          (rst),
        .frm_valid    (frm_valid),
        .frm_right    (frm_right),
        .frm_par_err  (frm_par_err),
        .frm_ctrl     (frm_ctrl),
        .frm_data     (frm_data),
        .blk_pulse    (blk_pulse),
        .viol_pulse   (viol_pulse),
        .sig_lost     (sig_lost),
        .lock         (lock),
        .left_sample  (left_sample),
        .left_ctrl    (left_ctrl),
        .right_sample (right_sample),
        .right_ctrl   (right_ctrl),
        .parity_err   (parity_err)
    );

endmodule

// File: tb/bmc_frame_decoder_bench.sv
module bmc_frame_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bmc_in = 1'b0;
    logic        lock, sig_lost, parity_err;
    logic [23:0] left_sample, right_sample;
    logic [3:0]  left_ctrl, right_ctrl;

    int tests = 0;
    int fails = 0;
    logic cur = 1'b0;
    logic done = 1'b0;

    logic [23:0] exp_l = '0, exp_r = '0;
    logic [3:0]  exp_lc = '0, exp_rc = '0;
    logic        exp_pe = 1'b0;

    always #4 clk = ~clk;

    bmc_frame_decoder #(.SAMPLE_W(24), .LOSS_CLKS(32), .BLOCK_FRAMES(2)) u_bmc_frame_decoder (
        .clk          (clk),
        .rst          (rst),
        .bmc_in       (bmc_in),
        .lock         (lock),
        .sig_lost     (sig_lost),
        .left_sample  (left_sample),
        .left_ctrl    (left_ctrl),
        .right_sample (right_sample),
        .right_ctrl   (right_ctrl),
        .parity_err   (parity_err)
    );

    // {kind[1:0] (0 block,1 left,2 right), bad parity, {C,U,V}, data[23:0]}
    localparam logic [29:0] VEC [8] = '{
        {2'd0, 1'b0, 3'b000, 24'h000001},
        {2'd2, 1'b0, 3'b101, 24'h800000},
        {2'd1, 1'b0, 3'b010, 24'hA5A5A5},
        {2'd2, 1'b1, 3'b111, 24'h123456},
        {2'd0, 1'b0, 3'b001, 24'hFFFFFF},
        {2'd2, 1'b0, 3'b000, 24'h000000},
        {2'd1, 1'b1, 3'b100, 24'h5A5A5A},
        {2'd2, 1'b0, 3'b110, 24'hC0FFEE}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic half(input logic lv);
        bmc_in = lv;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_pre(input logic [1:0] kind);
        logic [7:0] pat;
        logic       base;
        case (kind)
            2'd0:    pat = 8'b11101000;
            2'd1:    pat = 8'b11100010;
            2'd2:    pat = 8'b11100100;
            default: pat = 8'b11100001;
        endcase
        base = cur;
        for (int i = 7; i >= 0; i--) begin
            cur = pat[i] ^ base;
            half(cur);
        end
    endtask

    task automatic send_bit(input logic b);
        cur = ~cur;
        half(cur);
        if (b) cur = ~cur;
        half(cur);
    endtask

    task automatic send_body(input logic [23:0] d, input logic [2:0] cuv, input logic bad,
                             output logic [3:0] ctrl, output logic pe);
        logic p;
        p = (^d) ^ (^cuv) ^ bad;
        for (int i = 0; i < 24; i++) send_bit(d[i]);
        send_bit(cuv[0]);
        send_bit(cuv[1]);
        send_bit(cuv[2]);
        send_bit(p);
        ctrl = {p, cuv};
        pe   = bad;
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R1 left sample"},  {8'd0, left_sample},  {8'd0, exp_l});
        check({tag, " R1 right sample"}, {8'd0, right_sample}, {8'd0, exp_r});
        check({tag, " R2 left ctrl"},    {28'd0, left_ctrl},   {28'd0, exp_lc});
        check({tag, " R2 right ctrl"},   {28'd0, right_ctrl},  {28'd0, exp_rc});
        check({tag, " R5 parity_err"},   {31'd0, parity_err},  {31'd0, exp_pe});
    endtask

    task automatic store_exp(input logic [1:0] kind, input logic [23:0] d,
                             input logic [3:0] c, input logic pe);
        // R3: block and left patterns fill left, right pattern fills right; R4 other side kept
        if (kind == 2'd2) begin exp_r = d; exp_rc = c; end
        else              begin exp_l = d; exp_lc = c; end
        exp_pe = pe;
    endtask

    initial begin
        logic [3:0] c;
        logic       pe;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10 reset state
        check("R10 lock", {31'd0, lock}, 32'd0);
        check("R10 sig_lost", {31'd0, sig_lost}, 32'd1);
        check_outputs("R10");

        // Table walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 8; i++) begin
            send_pre(VEC[i][29:28]);
            if (i > 0) begin
                check_outputs("table");
                check("R7 lock held", {31'd0, lock}, 32'd1);
                check("R6 sig_lost low", {31'd0, sig_lost}, 32'd0);
            end
            send_body(VEC[i][23:0], VEC[i][26:24], VEC[i][27], c, pe);
            store_exp(VEC[i][29:28], VEC[i][23:0], c, pe);
        end
        send_pre(2'd1);
        check_outputs("table last");
        send_body(24'h111111, 3'b000, 1'b0, c, pe);
        store_exp(2'd1, 24'h111111, c, pe);

        // R9 violation: bad preamble, right body must not be stored
        send_pre(2'd3);
        send_body(24'h222222, 3'b000, 1'b0, c, pe);
        send_pre(2'd0);
        check("R9 lock dropped", {31'd0, lock}, 32'd0);
        check("R9 right unchanged", {8'd0, right_sample}, {8'd0, exp_r});
        check_outputs("R9");
        send_body(24'h333333, 3'b011, 1'b0, c, pe);
        store_exp(2'd0, 24'h333333, c, pe);

        // R8 window timeout
        send_pre(2'd1);
        check("R7 relock", {31'd0, lock}, 32'd1);
        check_outputs("R7 relock");
        send_body(24'h444444, 3'b000, 1'b0, c, pe);
        for (int j = 0; j < 8; j++) begin
            send_pre((j % 2 == 0) ? 2'd2 : 2'd1);
            if (j == 2) check("R8 lock inside window", {31'd0, lock}, 32'd1);
            send_body(24'h0F0F0F + j, 3'b000, 1'b0, c, pe);
        end
        send_pre(2'd2);
        check("R8 lock after window", {31'd0, lock}, 32'd0);
        send_body(24'h777777, 3'b000, 1'b0, c, pe);

        // R6 loss of input
        repeat (45) @(negedge clk);
        check("R6 sig_lost", {31'd0, sig_lost}, 32'd1);
        check("R6 lock low", {31'd0, lock}, 32'd0);
        exp_l = '0; exp_r = '0; exp_lc = '0; exp_rc = '0; exp_pe = 1'b0;
        check_outputs("R6");
        cur = ~cur;
        half(cur);
        repeat (4) @(negedge clk);
        check("R6 sig_lost cleared", {31'd0, sig_lost}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule